// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple host request port and an 8-bit-wide extended-data-out DRAM with a 21-bit word address. The host offers one request at a time as address, write flag and data, using a valid/ready handshake. The controller splits the address into an 11-bit row and a 10-bit column. It opens the row by dropping the row strobe, runs a column access by pulsing the column strobe, and then leaves the row open. A later request to the same row then costs only one column cycle.

The row is closed when one of three things happens: a request names a different row, a refresh is requested from outside, or the row has been open long enough that a further column cycle could break the maximum row-strobe low time. Writes are always early writes. The write strobe falls together with the column strobe, and the output enable stays high. Reads enable the device output together with the column strobe. The controller samples the data in the last column-low cycle and returns it with a one-cycle valid pulse. Every timing is a cycle count parameter that is sized for the clock.

Top module: `edo_page_ctrl`

## Requirements
- R1: When the row strobe falls, `dram_addr` carries request address bits [20:10]. When the column strobe falls, `dram_addr` carries address bits [9:0] with bit 10 at zero.
- R2: The column strobe is low only while the row strobe is low. It falls no sooner than T_RCD cycles after the row strobe. It stays low for exactly T_CAS cycles. It stays high for at least T_CP cycles before the next column.
- R3: For a write (`req_write`=1), the cycle in which the column strobe falls has `dram_we_n`=0, `dram_dq_oe`=1, the request data on `dram_dq_out` and `dram_oe_n`=1. `dram_dq_oe` is 0 again once the column strobe rises.
- R4: For a read, `dram_we_n`=1 and `dram_oe_n`=0 when the column strobe falls. The byte on `dram_dq_in` in the last column-low cycle appears on `rd_data` with `rd_valid` high for exactly one cycle, in request order.
- R5: A request to the row already open performs only a column cycle, and the row strobe does not fall again.
- R6: A request to a different row raises the row strobe. The strobe stays high for at least T_RP cycles, and the row then reopens with the new row address.
- R7: The row strobe is never low for more than MAX_RAS_CYC consecutive cycles. An open row closes by itself when its age limit is reached, even with no request pending.
- R8: While `refresh_req` is high, any open row is closed after its current column. No row opens, `req_ready` is 0, and `refresh_idle` is 1 once the controller is idle with the row strobe high.
- R9: After reset, all four strobes are high, `dram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R10: `dram_dq_oe` and a low `dram_oe_n` never occur together, and `dram_oe_n` is high whenever the row strobe is high.
- R11: A request is taken only in a cycle with `req_valid` and `req_ready` both high, and each accepted request produces exactly one column strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request is taken on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in [20:10], column in [9:0] |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| refresh_req | input | 1 | Close the row and hold the device idle |
| refresh_idle | output | 1 | Row closed and idle while refresh is requested |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Device output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data driven to the device |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_in | input | 8 | Data from the device |

## Verification
The bench builds the controller with its default strobe timings, which suit a 20 ns clock. It lowers MAX_RAS_CYC to 40 so that a stream of some twenty same-row requests, or a short idle gap, forces the age-limit close within a few dozen cycles. The bench also checks that six back-to-back hits still fit inside one open row. A behavioural device in the bench stores writes and returns reads at each column strobe fall. This lets misses, hits, refresh holds and the age limit all be judged from the strobe waveforms and the returned bytes.

// File: rtl/edoc_pkg.sv
package edoc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RCD, ST_CAS, ST_CP, ST_OPEN, ST_PRE
  } edoc_state_e;
endpackage

// File: rtl/edoc_timer.sv
module edoc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R2
  tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/edoc_row_track.sv
module edoc_row_track #(
  parameter int ROW_W     = 11,
  parameter int AGE_W     = 8,
  parameter int AGE_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hit_o,
  output logic             aged_o
);
  logic             valid_q;
  logic [ROW_W-1:0] row_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      row_q   <= '0;
      age_q   <= '0;
    end else if (open_i) begin
      valid_q <= 1'b1;
      row_q   <= row_i;
      age_q   <= '0;
    end else if (close_i) begin
      valid_q <= 1'b0;
    end else if (valid_q && age_q < AGE_W'(AGE_LIMIT)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign hit_o  = valid_q && (row_q == row_i);
  assign aged_o = (age_q >= AGE_W'(AGE_LIMIT));

  // R5
  open_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (open_i && $stable(row_i)) |=> (hit_o || !$stable(row_i)));
endmodule

// File: rtl/edoc_rd_capture.sv
module edoc_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= strobe;
      if (strobe) rd_data <= din;
    end
  end

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 10,
  parameter int DATA_W      = 8,
  parameter int T_RCD       = 1,
  parameter int T_CAS       = 1,
  parameter int T_CP        = 1,
  parameter int T_RP        = 2,
  parameter int MAX_RAS_CYC = 10000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   refresh_req,
  output logic                   refresh_idle,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  import edoc_pkg::*;

  localparam int TMAX_A    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TMAX_B    = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TMAX      = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMR_W     = $clog2(TMAX + 1);
  localparam int AGE_LIMIT = MAX_RAS_CYC - T_CAS - T_CP - 1;
  localparam int AGE_W     = $clog2(MAX_RAS_CYC + 2);

  edoc_state_e state;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic [COL_W-1:0]  cur_col;
  logic              cur_wr;
  logic [DATA_W-1:0] cur_data;
  logic              tmr_zero, tmr_load, hit, aged;
  logic [TMR_W-1:0]  tmr_val;
  logic go_row, go_col, end_col, end_cp, go_close, end_pre, open_take;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  assign req_ready = !refresh_req &&
    ((state == ST_IDLE) || (state == ST_OPEN && hit && !aged));
  assign refresh_idle = refresh_req && (state == ST_IDLE);

  assign go_row    = (state == ST_IDLE) && req_valid && req_ready;
  assign open_take = (state == ST_OPEN) && req_valid && req_ready;
  assign go_col    = ((state == ST_RCD) && tmr_zero) || open_take;
  assign end_col   = (state == ST_CAS) && tmr_zero;
  assign end_cp    = (state == ST_CP) && tmr_zero;
  assign go_close  = (state == ST_OPEN) &&
                     (refresh_req || aged || (req_valid && !hit));
  assign end_pre   = (state == ST_PRE) && tmr_zero;

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = '0;
    if (go_row)        tmr_val = TMR_W'(T_RCD - 1);
    else if (go_col)   tmr_val = TMR_W'(T_CAS - 1);
    else if (end_col)  tmr_val = TMR_W'(T_CP - 1);
    else if (go_close) tmr_val = TMR_W'(T_RP - 1);
    else               tmr_load = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      cur_col     <= '0;
      cur_wr      <= 1'b0;
      cur_data    <= '0;
    end else begin
      if (go_row) begin
        state      <= ST_RCD;
        dram_ras_n <= 1'b0;
        dram_addr  <= req_row;
        cur_col    <= req_col;
        cur_wr     <= req_write;
        cur_data   <= req_wdata;
      end else if (go_col) begin
        state       <= ST_CAS;
        dram_cas_n  <= 1'b0;
        dram_addr   <= ROW_W'(open_take ? req_col : cur_col);
        dram_we_n   <= open_take ? !req_write : !cur_wr;
        dram_oe_n   <= open_take ? req_write : cur_wr;
        dram_dq_oe  <= open_take ? req_write : cur_wr;
        dram_dq_out <= open_take ? req_wdata : cur_data;
        if (open_take) cur_wr <= req_write;
      end else if (end_col) begin
        state      <= ST_CP;
        dram_cas_n <= 1'b1;
        dram_we_n  <= 1'b1;
        dram_dq_oe <= 1'b0;
      end else if (end_cp) begin
        state     <= ST_OPEN;
        dram_oe_n <= 1'b1;
      end else if (go_close) begin
        state      <= ST_PRE;
        dram_ras_n <= 1'b1;
        dram_oe_n  <= 1'b1;
      end else if (end_pre) begin
        state <= ST_IDLE;
      end
    end
  end

  edoc_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  edoc_row_track #(.ROW_W(ROW_W), .AGE_W(AGE_W), .AGE_LIMIT(AGE_LIMIT)) u_rows (
    .clk(clk), .rst(rst), .open_i(go_row), .close_i(go_close),
    .row_i(req_row), .hit_o(hit), .aged_o(aged)
  );

  edoc_rd_capture #(.DW(DATA_W)) u_rdcap (
    .clk(clk), .rst(rst), .strobe(end_col && !cur_wr), .din(dram_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Row-strobe low-time watch for the assertion below
  logic [AGE_W-1:0] ras_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst || dram_ras_n) ras_lo_cnt <= '0;
    else if (ras_lo_cnt <= AGE_W'(MAX_RAS_CYC)) ras_lo_cnt <= ras_lo_cnt + 1'b1;
  end

  // R7
  ras_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ras_lo_cnt <= AGE_W'(MAX_RAS_CYC));
  // R2
  cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);
  // R6
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |=> dram_ras_n);
  // R10
  bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> dram_oe_n);
  // R10
  closed_off_chk: assert property (@(posedge clk) disable iff (rst)
    dram_ras_n |-> dram_oe_n);
  // R8
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_idle |=> dram_ras_n);
  // R3
  write_drive_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> !dram_dq_oe);
endmodule

// File: tb/edo_page_ctrl_bench.sv
module edo_page_ctrl_bench;
  localparam int MAXR = 40;
  localparam int TRCD = 1, TCAS = 1, TCP = 1, TRP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, refresh_idle;
  logic [7:0]  rd_data, dram_dq_out;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;
  logic [7:0]  dq_in_r = '0;

  edo_page_ctrl #(.MAX_RAS_CYC(MAXR)) u_edo_page_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
    .refresh_idle(refresh_idle), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_r)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mk(int row, int col);
    return row * 1024 + col;
  endfunction

  logic [7:0] shadow [int];
  logic [7:0] mem [int];
  logic [7:0] exp_q [$];

  int ras_falls = 0, cas_falls = 0, n_acc = 0;
  int ras_lo_run = 0, ras_hi_run = 0, cas_lo_run = 0;
  int max_ras_lo = 0, min_pre = 1000;
  bit seen_low = 0, fight = 0, rdv_wide = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_rdv = 1'b0;
  int exp_row = 0, exp_col = 0, m_row = 0;
  logic [7:0] exp_wd = '0;

  // Device model, strobe timing monitor and scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (!dram_ras_n && prev_ras) begin
        ras_falls++;
        chk(int'(dram_addr) == exp_row, "R1 row address", dram_addr, exp_row);
        if (seen_low) begin
          chk(ras_hi_run >= TRP, "R6 precharge width", ras_hi_run, TRP);
          if (ras_hi_run < min_pre) min_pre = ras_hi_run;
        end
        seen_low = 1;
        m_row = dram_addr;
      end
      ras_lo_run = dram_ras_n ? 0 : ras_lo_run + 1;
      ras_hi_run = dram_ras_n ? ras_hi_run + 1 : 0;
      if (ras_lo_run > max_ras_lo) max_ras_lo = ras_lo_run;

      if (!dram_cas_n && prev_cas) begin
        cas_falls++;
        chk(dram_addr == 11'(exp_col), "R1 column address", dram_addr, exp_col);
        chk(!dram_ras_n && ras_lo_run >= TRCD + 1, "R2 row-to-column delay",
            ras_lo_run, TRCD + 1);
        if (!dram_we_n) begin
          chk(dram_dq_oe && dram_oe_n && dram_dq_out == exp_wd, "R3 early write",
              {dram_dq_oe, dram_oe_n, dram_dq_out}, {2'b11, exp_wd});
          mem[mk(m_row, int'(dram_addr[9:0]))] = dram_dq_out;
        end else begin
          chk(!dram_oe_n && !dram_dq_oe, "R4 read enables", dram_oe_n, 0);
          dq_in_r <= mem.exists(mk(m_row, int'(dram_addr[9:0]))) ?
                     mem[mk(m_row, int'(dram_addr[9:0]))] : 8'h00;
        end
      end
      if (dram_cas_n && !prev_cas) begin
        chk(cas_lo_run == TCAS, "R2 column low width", cas_lo_run, TCAS);
        chk(!dram_dq_oe, "R3 bus released", dram_dq_oe, 0);
      end
      cas_lo_run = dram_cas_n ? 0 : cas_lo_run + 1;

      if (dram_dq_oe && !dram_oe_n) fight = 1;
      if (dram_ras_n && !dram_oe_n) fight = 1;
      if (rd_valid && prev_rdv) rdv_wide = 1;

      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected read", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R4 read data", rd_data, e);
        end
      end

      if (req_valid && req_ready) begin
        n_acc++;
        exp_row = int'(req_addr[20:10]);
        exp_col = int'(req_addr[9:0]);
        exp_wd  = req_wdata;
        if (req_write) shadow[int'(req_addr)] = req_wdata;
        else exp_q.push_back(shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'h00);
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_rdv = rd_valid;
    end
  end

  task automatic do_req(bit wr, int addr, logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = 21'(addr); req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int rf;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R9 strobes high",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hf);
    chk(!dram_dq_oe && !rd_valid && req_ready, "R9 idle outputs",
        {dram_dq_oe, rd_valid, req_ready}, 3'b001);

    // R5: six accesses to one row, one row opening
    rf = ras_falls;
    for (int c = 1; c <= 3; c++) do_req(1, mk(5, c), 8'(8'h10 + c));
    for (int c = 1; c <= 3; c++) do_req(0, mk(5, c), 0);
    settle();
    chk(ras_falls == rf + 1, "R5 hits stay in row", ras_falls, rf + 1);

    // R6: misses close and reopen
    rf = ras_falls;
    do_req(1, mk(9, 7), 8'h5a);
    settle();
    chk(ras_falls == rf + 1, "R6 miss reopens", ras_falls, rf + 1);
    do_req(0, mk(5, 2), 0);
    do_req(0, mk(9, 7), 0);
    settle();
    chk(ras_falls == rf + 3, "R6 miss count", ras_falls, rf + 3);

    // R7: long same-row stream crosses the age limit
    rf = ras_falls;
    for (int i = 0; i < 10; i++) begin
      do_req(1, mk(12, i), 8'(i * 7 + 3));
      do_req(0, mk(12, i), 0);
    end
    settle();
    chk(ras_falls >= rf + 2, "R7 aged row closes", ras_falls, rf + 2);
    repeat (60) @(posedge clk);
    #1;
    chk(dram_ras_n == 1'b1, "R7 idle row closes", dram_ras_n, 1);

    // R8: refresh closes the row and blocks openings
    do_req(1, mk(3, 4), 8'h77);
    @(posedge clk); #1 refresh_req = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    chk(refresh_idle && dram_ras_n && !req_ready, "R8 idle under refresh",
        {refresh_idle, dram_ras_n, req_ready}, 3'b110);
    rf = ras_falls;
    fork
      do_req(0, mk(3, 4), 0);
      begin
        repeat (10) @(posedge clk);
        #1;
        chk(ras_falls == rf && dram_ras_n, "R8 request held off", ras_falls, rf);
        refresh_req = 1'b0;
      end
    join
    settle();
    chk(ras_falls == rf + 1, "R8 resumes after refresh", ras_falls, rf + 1);

    // R1: scattered rows and columns
    for (int i = 0; i < 8; i++)
      do_req(1, mk((i * 37 + 1) % 2048, (i * 101 + 5) % 1024), 8'(i * 13 + 1));
    for (int i = 7; i >= 0; i--)
      do_req(0, mk((i * 37 + 1) % 2048, (i * 101 + 5) % 1024), 0);

    while (exp_q.size() != 0) @(posedge clk);
    repeat (5) @(posedge clk);
    #1;
    chk(max_ras_lo <= MAXR, "R7 row low limit", max_ras_lo, MAXR);
    chk(min_pre >= TRP, "R6 minimum precharge", min_pre, TRP);
    chk(!fight, "R10 output enable rules", fight, 0);
    chk(!rdv_wide, "R4 one-cycle valid", rdv_wide, 0);
    chk(cas_falls == n_acc, "R11 one column per request", cas_falls, n_acc);
    finish_run();
  end
endmodule